// File: doc/BRIEF.md
# Serial Configuration Write Port

This block is the configuration entry point of an imaging front end. A host drives three wires: a serial clock, a data line and an active-low load strobe. While the strobe is low the block collects a frame made of a test bit, a three-bit register address and one or more twelve-bit data words. Every word is parked in a shadow copy of its target register. Nothing reaches the live configuration until the strobe rises. At that moment every parked word takes effect in the same cycle, so the analog chain never sees a half-updated set of settings.

The three wires are brought into the system clock domain by a synchronizer, and the block acts on detected edges. There are four live registers: operation (software reset, power mode, clamp disable, blank level), control (four input polarities, output three-state, latch mode, Gray output), black clamp level and amplifier gain. Their fields appear as separate output ports. If the strobe stays low after a word, the next word goes to the next address. Until a power-on lockout window has elapsed, the block ignores everything on the wires.

Top module: `serial_cfg_port`

## Requirements
- R1: Data bits are taken only on rising serial-clock edges seen while the load strobe is low. Serial-clock activity while the strobe is high has no effect on the configuration and leaves no state behind for the next frame.
- R2: A frame sends, in this order, one test bit, address bits A0 to A2, and then data bits D0 to D11. Both the address and the data go LSB first. Data bits above a register's field width are accepted and ignored.
- R3: A completed word changes no output while the strobe is still low. All words staged in a frame appear at the outputs together, a few system clocks after the strobe rises.
- R4: When the strobe stays low after a complete word, the next twelve bits go to the next address, counting modulo 8. Addresses 4 to 7 accept words but store nothing.
- R5: A word that is cut short by the strobe rising is dropped. Every frame starts its address from the bits it sends, whatever earlier frames did.
- R6: A frame whose test bit is 1 stages no word at all.
- R7: After reset every output is 0, except the black clamp level, which is 128.
- R8: Address 0 controls the operation fields. D0 is software reset. D2:D1 set the power mode (00 normal, 01 standby, 10 shutdown), D3 disables the clamp, and D6 sets the blank level.
- R9: Address 1 controls the control fields. D0 is the sample-clock polarity, D1 the data-clock polarity, D2 the clamp polarity, D3 the blank polarity, D4 output three-state, D5 transparent latch and D6 Gray coding.
- R10: Address 2 D7:D0 hold the black clamp level. Address 3 D9:D0 hold the gain code, where 0 is the lowest gain and 1023 the highest.
- R11: When an operation word with D0 = 1 is committed, every register returns to its reset value. Any other word staged in the same frame is dropped.
- R12: For LOCK_CYCLES system clocks after reset, frames and strobe edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, starts the lockout window |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_data | input | 1 | Serial data line |
| ser_load | input | 1 | Load strobe: low frames a write, rising edge commits |
| pwr_mode | output | 2 | Power mode: 00 normal, 01 standby, 10 shutdown |
| clamp_bypass | output | 1 | 1 disables the black clamp loop |
| blank_to_black | output | 1 | 1 blanks to the clamp level, 0 blanks to zero |
| pol_sample | output | 1 | Sampling clock polarity, 1 active high |
| pol_dclk | output | 1 | Data clock polarity, 1 active high |
| pol_clamp | output | 1 | Clamp pulse polarity, 1 active high |
| pol_blank | output | 1 | Blank pulse polarity, 1 active high |
| dout_hiz | output | 1 | 1 puts the data outputs in three-state |
| dout_transparent | output | 1 | 1 makes the output latch transparent |
| dout_gray | output | 1 | 1 selects Gray-coded output data |
| black_level | output | 8 | Black clamp target level |
| gain_code | output | 10 | Amplifier gain code |

## Verification
A fault in the bit counter or the address register shows up as a value landing in the wrong field or not landing at all. It becomes visible within about three system clocks after the strobe rises. A shadow flag that fails to clear, or that is set by mistake, makes an output change at a commit that should not touch it. A lockout counter that ends early makes the first write of the run take effect. Partial-word, test-bit and idle-clock faults only appear after the next commit. For that reason each of those cases ends with a commit, followed by a compare of every field.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int ADDR_W    = 3;
  localparam int WORD_BITS = 12;
  localparam int KEEP_BITS = 10;
  localparam int CNT_W     = $clog2(WORD_BITS);
  localparam int CLAMP_W   = 8;
  localparam int GAIN_W    = 10;
  localparam int NUM_REGS  = 4;

  localparam logic [ADDR_W-1:0] A_OP    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLAMP = 3'd2;
  localparam logic [ADDR_W-1:0] A_GAIN  = 3'd3;

  localparam logic [CLAMP_W-1:0] CLAMP_DEFAULT = 8'd128;

  typedef struct packed {
    logic       blank_lvl;
    logic       clamp_off;
    logic [1:0] pwr;
  } op_t;

  typedef struct packed {
    logic gray;
    logic transp;
    logic hiz;
    logic pol_blank;
    logic pol_clamp;
    logic pol_dclk;
    logic pol_sample;
  } ctl_t;

  // address step inside a burst; wraps modulo the address space
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  // true when a header or data field has received its final bit
  function automatic logic field_done(input logic [CNT_W-1:0] cnt, input int len);
    return cnt == CNT_W'(len - 1);
  endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] level
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= IDLE;
    end else begin
      stage_q[0] <= pin;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign level = stage_q[STAGES-1];

endmodule

// File: rtl/scp_frame_rx.sv
module scp_frame_rx
  import scp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 bit_stb,
  input  logic                 bit_val,
  output logic                 word_stb,
  output logic [ADDR_W-1:0]    word_addr,
  output logic [KEEP_BITS-1:0] word_data
);

  typedef enum logic [1:0] {PH_TEST, PH_ADDR, PH_DATA} phase_e;

  phase_e               ph;
  logic [CNT_W-1:0]     cnt;
  logic                 bad;
  logic [ADDR_W-1:0]    addr;
  logic [KEEP_BITS-1:0] sh;
  logic                 data_last;

  assign data_last = field_done(cnt, WORD_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_TEST;
      cnt  <= '0;
      bad  <= 1'b0;
      addr <= '0;
      sh   <= '0;
    end else if (!en) begin
      ph   <= PH_TEST;
      cnt  <= '0;
      bad  <= 1'b0;
      addr <= '0;
    end else if (bit_stb) begin
      unique case (ph)
        PH_TEST: begin
          bad <= bit_val;
          cnt <= '0;
          ph  <= PH_ADDR;
        end
        PH_ADDR: begin
          addr <= {bit_val, addr[ADDR_W-1:1]};
          if (field_done(cnt, ADDR_W)) begin
            cnt <= '0;
            ph  <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt < CNT_W'(KEEP_BITS)) sh[cnt] <= bit_val;
          if (data_last) begin
            cnt  <= '0;
            addr <= next_addr(addr);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign word_stb  = en & bit_stb & (ph == PH_DATA) & data_last & ~bad;
  assign word_addr = addr;
  assign word_data = sh;

  // R4: a delivered word moves the frame to the next address
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> (word_addr == next_addr($past(word_addr))));

endmodule

// File: rtl/scp_reg_bank.sv
module scp_reg_bank
  import scp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_stb,
  input  logic [ADDR_W-1:0]    word_addr,
  input  logic [KEEP_BITS-1:0] word_data,
  input  logic                 commit,
  output op_t                  op_q,
  output ctl_t                 ctl_q,
  output logic [CLAMP_W-1:0]   clamp_q,
  output logic [GAIN_W-1:0]    gain_q
);

  op_t                op_s;
  logic               sw_s;
  ctl_t               ctl_s;
  logic [CLAMP_W-1:0] clamp_s;
  logic [GAIN_W-1:0]  gain_s;
  logic [NUM_REGS-1:0] vld;
  logic               sw_fire;

  assign sw_fire = commit & vld[A_OP] & sw_s;

  // shadow copies, one valid flag per register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_s    <= '0;
      sw_s    <= 1'b0;
      ctl_s   <= '0;
      clamp_s <= '0;
      gain_s  <= '0;
      vld     <= '0;
    end else if (commit) begin
      vld <= '0;
    end else if (word_stb) begin
      unique case (word_addr)
        A_OP: begin
          sw_s         <= word_data[0];
          op_s.pwr     <= word_data[2:1];
          op_s.clamp_off <= word_data[3];
          op_s.blank_lvl <= word_data[6];
          vld[A_OP]    <= 1'b1;
        end
        A_CTL: begin
          ctl_s      <= ctl_t'(word_data[6:0]);
          vld[A_CTL] <= 1'b1;
        end
        A_CLAMP: begin
          clamp_s      <= word_data[CLAMP_W-1:0];
          vld[A_CLAMP] <= 1'b1;
        end
        A_GAIN: begin
          gain_s      <= word_data[GAIN_W-1:0];
          vld[A_GAIN] <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // live registers, all updated in the commit cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || 1'b0) begin
      op_q    <= '0;
      ctl_q   <= '0;
      clamp_q <= CLAMP_DEFAULT;
      gain_q  <= '0;
    end else if (sw_fire) begin
      op_q    <= '0;
      ctl_q   <= '0;
      clamp_q <= CLAMP_DEFAULT;
      gain_q  <= '0;
    end else if (commit) begin
      if (vld[A_OP])    op_q    <= op_s;
      if (vld[A_CTL])   ctl_q   <= ctl_s;
      if (vld[A_CLAMP]) clamp_q <= clamp_s;
      if (vld[A_GAIN])  gain_q  <= gain_s;
    end
  end

  // R3: live fields only move in a commit cycle
  a_r3_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(op_q) && $stable(ctl_q) && $stable(clamp_q) && $stable(gain_q)));

  // R11: a committed software reset leaves only defaults
  a_r11_swreset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    sw_fire |=> (op_q == '0 && ctl_q == '0 && clamp_q == CLAMP_DEFAULT && gain_q == '0));

endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import scp_pkg::*;
#(
  parameter int LOCK_CYCLES = 40000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_load,
  output logic [1:0]         pwr_mode,
  output logic               clamp_bypass,
  output logic               blank_to_black,
  output logic               pol_sample,
  output logic               pol_dclk,
  output logic               pol_clamp,
  output logic               pol_blank,
  output logic               dout_hiz,
  output logic               dout_transparent,
  output logic               dout_gray,
  output logic [CLAMP_W-1:0] black_level,
  output logic [GAIN_W-1:0]  gain_code
);

  localparam int LCW = $clog2(LOCK_CYCLES + 1);

  logic [2:0] pins_s;
  logic       sck_s, sda_s, load_s;
  logic       sck_d, load_d;
  logic       sck_rise, load_rise;
  logic [LCW-1:0] lock_cnt;
  logic       unlocked;
  logic       frame_en, commit;

  logic                 word_stb;
  logic [ADDR_W-1:0]    word_addr;
  logic [KEEP_BITS-1:0] word_data;
  op_t                  op_q;
  ctl_t                 ctl_q;

  scp_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   ({ser_load, ser_data, ser_clk}),
    .level (pins_s)
  );

  assign {load_s, sda_s, sck_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      load_d <= 1'b1;
    end else begin
      sck_d  <= sck_s;
      load_d <= load_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_d;
  assign load_rise = load_s & ~load_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lock_cnt <= '0;
    else if (!unlocked) lock_cnt <= lock_cnt + 1'b1;
  end

  assign unlocked = (lock_cnt == LCW'(LOCK_CYCLES));
  assign frame_en = ~load_s & unlocked;
  assign commit   = load_rise & unlocked;

  scp_frame_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (frame_en),
    .bit_stb   (sck_rise),
    .bit_val   (sda_s),
    .word_stb  (word_stb),
    .word_addr (word_addr),
    .word_data (word_data)
  );

  scp_reg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_stb  (word_stb),
    .word_addr (word_addr),
    .word_data (word_data),
    .commit    (commit),
    .op_q      (op_q),
    .ctl_q     (ctl_q),
    .clamp_q   (black_level),
    .gain_q    (gain_code)
  );

  assign pwr_mode         = op_q.pwr;
  assign clamp_bypass     = op_q.clamp_off;
  assign blank_to_black   = op_q.blank_lvl;
  assign pol_sample       = ctl_q.pol_sample;
  assign pol_dclk         = ctl_q.pol_dclk;
  assign pol_clamp        = ctl_q.pol_clamp;
  assign pol_blank        = ctl_q.pol_blank;
  assign dout_hiz         = ctl_q.hiz;
  assign dout_transparent = ctl_q.transp;
  assign dout_gray        = ctl_q.gray;

  // R12: nothing is delivered while the lockout window runs
  a_r12_locked_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !word_stb);

  // R1: no word is delivered while the strobe is seen high
  a_r1_loaded_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    load_s |-> !word_stb);

endmodule

// File: tb/serial_cfg_port_test.sv
`timescale 1ns/1ps
module serial_cfg_port_test;

  localparam int LOCK = 400;
  localparam int HALF = 3;
  localparam int NV   = 8;
  localparam logic [14:0] VEC [NV] = '{
    {3'd3, 12'h3FF}, {3'd2, 12'h055}, {3'd0, 12'h04A}, {3'd1, 12'h07F},
    {3'd3, 12'hC01}, {3'd0, 12'h004}, {3'd1, 12'h050}, {3'd2, 12'h0FF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b1;
  logic [1:0] pwr_mode;
  logic clamp_bypass, blank_to_black, pol_sample, pol_dclk, pol_clamp, pol_blank;
  logic dout_hiz, dout_transparent, dout_gray;
  logic [7:0] black_level;
  logic [9:0] gain_code;

  int runs = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic [11:0] m_w [4];
  logic [11:0] st_w [4];
  bit          st_v [4];

  always #10 clk = ~clk;

  serial_cfg_port #(.LOCK_CYCLES(LOCK)) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .pwr_mode(pwr_mode), .clamp_bypass(clamp_bypass), .blank_to_black(blank_to_black),
    .pol_sample(pol_sample), .pol_dclk(pol_dclk), .pol_clamp(pol_clamp), .pol_blank(pol_blank),
    .dout_hiz(dout_hiz), .dout_transparent(dout_transparent), .dout_gray(dout_gray),
    .black_level(black_level), .gain_code(gain_code)
  );

  function automatic logic [28:0] got_pack();
    return {pwr_mode, clamp_bypass, blank_to_black, pol_sample, pol_dclk, pol_clamp,
            pol_blank, dout_hiz, dout_transparent, dout_gray, black_level, gain_code};
  endfunction

  function automatic logic [28:0] exp_pack();
    return {m_w[0][2:1], m_w[0][3], m_w[0][6], m_w[1][0], m_w[1][1], m_w[1][2], m_w[1][3],
            m_w[1][4], m_w[1][5], m_w[1][6], m_w[2][7:0], m_w[3][9:0]};
  endfunction

  task automatic model_defaults();
    m_w[0] = '0; m_w[1] = '0; m_w[2] = 12'd128; m_w[3] = '0;
    for (int i = 0; i < 4; i++) st_v[i] = 1'b0;
  endtask

  task automatic model_stage(input int a, input logic [11:0] w);
    if (a < 4) begin st_w[a] = w; st_v[a] = 1'b1; end
  endtask

  task automatic model_commit();
    if (st_v[0] && st_w[0][0]) model_defaults();
    else for (int i = 0; i < 4; i++) if (st_v[i]) m_w[i] = st_w[i];
    for (int i = 0; i < 4; i++) st_v[i] = 1'b0;
  endtask

  task automatic check(input string tag);
    logic [28:0] g, e;
    g = got_pack(); e = exp_pack();
    runs++;
    if (g !== e) begin
      fails++;
      $display("FAIL %s: outputs got %h expected %h", tag, g, e);
    end
  endtask

  task automatic put_bit(input logic b);
    ser_data = b; ser_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic begin_frame(input logic tbit, input logic [2:0] a);
    ser_load = 1'b0; ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    put_bit(tbit);
    for (int i = 0; i < 3; i++) put_bit(a[i]);
  endtask

  task automatic put_word(input logic [11:0] w, input int n);
    for (int i = 0; i < n; i++) put_bit(w[i]);
  endtask

  task automatic end_frame();
    ser_clk = 1'b0;
    repeat (HALF) @(negedge clk);
    ser_load = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      fails++; runs++;
      $display("FAIL watchdog: cycles got %0d expected below 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    model_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset values");

    // R12: a full frame inside the lockout window is ignored
    begin_frame(1'b0, 3'd3);
    put_word(12'h155, 12);
    end_frame();
    check("R12 write during lockout");
    repeat (LOCK) @(negedge clk);

    // R2/R8/R9/R10 vector walk
    for (int v = 0; v < NV; v++) begin
      begin_frame(1'b0, VEC[v][14:12]);
      put_word(VEC[v][11:0], 12);
      end_frame();
      model_stage(int'(VEC[v][14:12]), VEC[v][11:0]);
      model_commit();
      case (VEC[v][14:12])
        3'd0:    check("R2 R8 operation word");
        3'd1:    check("R2 R9 control word");
        default: check("R2 R10 level/gain word");
      endcase
    end

    // R3: a staged word is invisible until the strobe rises
    begin_frame(1'b0, 3'd3);
    put_word(12'h2AB, 12);
    ser_clk = 1'b0;
    repeat (8) @(negedge clk);
    check("R3 no change before strobe");
    end_frame();
    model_stage(3, 12'h2AB); model_commit();
    check("R3 change after strobe");

    // R4: burst from address 2 wraps through 7 to 0 and 1
    begin_frame(1'b0, 3'd2);
    put_word(12'h033, 12);
    put_word(12'h111, 12);
    for (int k = 0; k < 4; k++) put_word(12'hFFF, 12);
    put_word(12'h048, 12);
    put_word(12'h025, 12);
    end_frame();
    model_stage(2, 12'h033); model_stage(3, 12'h111);
    model_stage(0, 12'h048); model_stage(1, 12'h025); model_commit();
    check("R4 burst auto-increment");

    // R5: partial second word dropped
    begin_frame(1'b0, 3'd2);
    put_word(12'h0AA, 12);
    put_word(12'h155, 9);
    end_frame();
    model_stage(2, 12'h0AA); model_commit();
    check("R5 partial word dropped");
    // R5: next frame starts from its own address
    begin_frame(1'b0, 3'd3);
    put_word(12'h0C3, 12);
    end_frame();
    model_stage(3, 12'h0C3); model_commit();
    check("R5 address restarts per frame");

    // R6: test bit set discards the frame
    begin_frame(1'b1, 3'd3);
    put_word(12'h3FE, 12);
    end_frame();
    check("R6 test bit frame ignored");

    // R1: clock toggling with strobe high leaves nothing behind
    for (int k = 0; k < 20; k++) begin
      ser_data = k[0] ^ k[2];
      ser_clk = ~ser_clk;
      repeat (HALF) @(negedge clk);
    end
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    begin_frame(1'b0, 3'd2);
    put_word(12'h05A, 12);
    end_frame();
    model_stage(2, 12'h05A); model_commit();
    check("R1 idle clocks ignored");

    // R11: software reset wins over words of the same frame
    begin_frame(1'b0, 3'd0);
    put_word(12'h001, 12);
    put_word(12'h07F, 12);
    put_word(12'h0EE, 12);
    put_word(12'h3FF, 12);
    end_frame();
    model_stage(0, 12'h001); model_stage(1, 12'h07F);
    model_stage(2, 12'h0EE); model_stage(3, 12'h3FF); model_commit();
    check("R11 software reset");

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

endmodule